// File: doc/BRIEF.md
# Bit and Byte Reversal / Leading Count Unit

This block is a single-operand integer data-processing stage. From one 64-bit operand it produces one of these: the operand with its bits mirrored, the operand with its bytes swapped in one of three groupings, the number of leading zero bits, or the number of leading bits that repeat the sign bit. A width flag selects 64-bit or 32-bit operation. In 32-bit operation only the low word of the operand is read, and the result is zero-extended to 64 bits.

The operation code and width flag are sampled together with the operand on every clock. The result is registered, so it appears one clock later. The byte-swap paths all use one permutation network, in which output byte j takes input byte (j XOR mask) and the mask picks the grouping. The two counters use one leading-zero scanner. Instruction decoding and register writeback belong to the surrounding pipeline.

Top module: `brx_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` is cleared to zero on that edge.
- R2: The result for the inputs sampled at one rising edge appears on `result_o` right after that edge. A new operation may be issued on every cycle.
- R3: Opcode 0 (bit mirror): bit i of the N-bit operand moves to result bit N-1-i. N is 64 when `wide_i`=1 and 32 when `wide_i`=0.
- R4: Opcode 1 (swap within halfwords): result byte j (byte 0 is least significant) is operand byte j XOR 1.
- R5: Opcode 2 (swap within words): result byte j is operand byte j XOR 3.
- R6: Opcode 3 (full reverse): with `wide_i`=1, result byte j is operand byte 7-j. With `wide_i`=0 it behaves exactly like opcode 2 on the low word.
- R7: Opcode 4 (leading zeros): the result is the number of zero bits above the highest set bit of the N-bit operand. It is N when the operand is zero.
- R8: Opcode 5 (leading sign bits): the result is the number of bits directly below the MSB of the N-bit operand that equal the MSB. Its range is 0 to N-1.
- R9: With `wide_i`=0, operand bits 63:32 have no effect, and result bits 63:32 are zero for every opcode.
- R10: Opcodes 6 and 7 are reserved and give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| operand_i | input | 64 | Source operand |
| opsel_i | input | 3 | Operation code (0 mirror, 1 half swap, 2 word swap, 3 full swap, 4 leading zeros, 5 leading sign bits, 6/7 reserved) |
| wide_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| result_o | output | 64 | Registered result |

## Verification
The assertions assume that `opsel_i`, `wide_i` and `operand_i` hold known (non-X) values at every rising edge once reset is released. They also assume each result is judged against the inputs of the previous edge alone, since the block keeps no other state. The stimulus holds to this: inputs change only on falling edges, are driven to defined values before reset is released, and the result is sampled one edge later. Directed patterns (zero, all ones, single bits at both ends of each width, alternating patterns and garbage in the ignored upper word) are mixed with pseudo-random operands under both widths.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned BRX_DATA_W = 64;
  localparam int unsigned BRX_LANE_W = 8;

  typedef enum logic [2:0] {
    OP_MIRROR    = 3'd0,
    OP_SWAP_HALF = 3'd1,
    OP_SWAP_WORD = 3'd2,
    OP_SWAP_ALL  = 3'd3,
    OP_LZC       = 3'd4,
    OP_LSC       = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } brx_op_e;
endpackage

// File: rtl/brx_bitrev.sv
module brx_bitrev #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/brx_byteperm.sv
module brx_byteperm #(
  parameter int unsigned W    = 64,
  parameter int unsigned LANE = 8,
  localparam int unsigned NB   = W / LANE,
  localparam int unsigned SELW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [W-1:0]    din,
  input  logic [SELW-1:0] xor_mask,
  output logic [W-1:0]    dout
);
  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [SELW-1:0] src;
    assign src = SELW'(j) ^ xor_mask;
    assign dout[j*LANE +: LANE] = din[src*LANE +: LANE];
  end
endmodule

// File: rtl/brx_lzcount.sv
module brx_lzcount #(
  parameter int unsigned W  = 64,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  always_comb begin
    logic found;
    found = 1'b0;
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && din[i]) begin
        count = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int unsigned DATA_W = BRX_DATA_W,
  parameter int unsigned LANE_W = BRX_LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [2:0]        opsel_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NB     = DATA_W / LANE_W;
  localparam int unsigned SELW   = $clog2(NB);
  localparam int unsigned CW     = $clog2(DATA_W + 1);
  localparam logic [SELW-1:0] MASK_HALF   = SELW'(1);
  localparam logic [SELW-1:0] MASK_WORD   = SELW'((HALF_W / LANE_W) - 1);
  localparam logic [SELW-1:0] MASK_ALL    = SELW'(NB - 1);

  brx_op_e op;
  assign op = brx_op_e'(opsel_i);

  logic [DATA_W-1:0] perm_src, mirror_src, mirror_out, perm_out;
  logic [DATA_W-1:0] signfix, count_src, next_result;
  logic [SELW-1:0]   perm_mask;
  logic [CW-1:0]     lead_cnt;
  logic              top_bit;

  always_comb begin
    perm_src   = wide_i ? operand_i : {{HALF_W{1'b0}}, operand_i[HALF_W-1:0]};
    mirror_src = wide_i ? operand_i : {operand_i[HALF_W-1:0], {HALF_W{1'b0}}};
    unique case (op)
      OP_SWAP_HALF: perm_mask = MASK_HALF;
      OP_SWAP_WORD: perm_mask = MASK_WORD;
      OP_SWAP_ALL:  perm_mask = wide_i ? MASK_ALL : MASK_WORD;
      default:      perm_mask = '0;
    endcase
    top_bit   = wide_i ? operand_i[DATA_W-1] : operand_i[HALF_W-1];
    signfix   = (op == OP_LSC && top_bit) ? ~operand_i : operand_i;
    count_src = wide_i ? signfix : {signfix[HALF_W-1:0], {HALF_W{1'b1}}};
  end

  brx_bitrev #(.W(DATA_W)) u_mirror (
    .din  (mirror_src),
    .dout (mirror_out)
  );

  brx_byteperm #(.W(DATA_W), .LANE(LANE_W)) u_perm (
    .din      (perm_src),
    .xor_mask (perm_mask),
    .dout     (perm_out)
  );

  brx_lzcount #(.W(DATA_W)) u_lzc (
    .din   (count_src),
    .count (lead_cnt)
  );

  always_comb begin
    unique case (op)
      OP_MIRROR:    next_result = mirror_out;
      OP_SWAP_HALF,
      OP_SWAP_WORD,
      OP_SWAP_ALL:  next_result = perm_out;
      OP_LZC:       next_result = DATA_W'(lead_cnt);
      OP_LSC:       next_result = DATA_W'(lead_cnt - CW'(1));
      default:      next_result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= next_result;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> result_o == '0); // R1
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    !wide_i |=> result_o[DATA_W-1:HALF_W] == '0); // R9
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (opsel_i == 3'd6 || opsel_i == 3'd7) |=> result_o == '0); // R10
  AST_LZC_ALLZERO: assert property (@(posedge clk) disable iff (rst)
    (opsel_i == 3'd4 && wide_i && operand_i == '0) |=> result_o == DATA_W'(DATA_W)); // R7
  AST_LZC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (opsel_i == 3'd4 && !wide_i) |=> result_o <= DATA_W'(HALF_W)); // R7
  AST_LSC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (opsel_i == 3'd5) |=> result_o < DATA_W'(DATA_W)); // R8
  AST_MIRROR_ONES: assert property (@(posedge clk) disable iff (rst)
    (opsel_i == 3'd0 && wide_i) |=> $countones(result_o) == $countones($past(operand_i))); // R3
  AST_SWAP_ONES: assert property (@(posedge clk) disable iff (rst)
    (opsel_i == 3'd3 && wide_i) |=> $countones(result_o) == $countones($past(operand_i))); // R6
endmodule

// File: tb/tb_brx_unit.sv
`timescale 1ns/1ps
module tb_brx_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] operand_i;
  logic [2:0]  opsel_i;
  logic        wide_i;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] lfsr = 64'hC0FF_EE12_3456_789B;

  always #10 clk = ~clk;

  brx_unit dut (
    .clk(clk), .rst(rst), .operand_i(operand_i),
    .opsel_i(opsel_i), .wide_i(wide_i), .result_o(result_o)
  );

  function automatic logic [63:0] model(input logic [2:0] op, input logic w,
                                        input logic [63:0] x);
    int n;
    logic [63:0] v, r;
    int m;
    n = w ? 64 : 32;
    v = w ? x : {32'h0, x[31:0]};
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < n; i++) r[n-1-i] = v[i];
      3'd1, 3'd2, 3'd3: begin
        m = (op == 3'd1) ? 1 : (op == 3'd2) ? 3 : (w ? 7 : 3);
        for (int j = 0; j < 8; j++) r[j*8 +: 8] = v[(j ^ m)*8 +: 8];
      end
      3'd4: begin
        int c;
        c = 0;
        for (int i = n - 1; i >= 0; i--) begin
          if (v[i]) break;
          c++;
        end
        r = 64'(c);
      end
      3'd5: begin
        int c;
        c = 0;
        for (int i = n - 2; i >= 0; i--) begin
          if (v[i] != v[n-1]) break;
          c++;
        end
        r = 64'(c);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] op, input logic w,
                        input logic [63:0] x);
    @(negedge clk);
    operand_i = x; opsel_i = op; wide_i = w;
    @(posedge clk); #1;
    check(req, result_o, model(op, w, x));
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    operand_i = 64'hFFFF_FFFF_FFFF_FFFF; opsel_i = 3'd0; wide_i = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset", result_o, 64'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_mirror();
    run_op("R3 mirror64", 3'd0, 1'b1, 64'h0000_0000_0000_0001);
    check("R3 mirror64 msb", result_o, 64'h8000_0000_0000_0000);
    run_op("R3 mirror32", 3'd0, 1'b0, 64'h0000_0000_0000_0001);
    check("R3 mirror32 bit31", result_o, 64'h0000_0000_8000_0000);
    run_op("R3 mirror64 pat", 3'd0, 1'b1, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_swaps();
    run_op("R4 half64", 3'd1, 1'b1, 64'h0011_2233_4455_6677);
    check("R4 half64 lit", result_o, 64'h1100_3322_5544_7766);
    run_op("R4 half32", 3'd1, 1'b0, 64'hDEAD_BEEF_0011_2233);
    run_op("R5 word64", 3'd2, 1'b1, 64'h0011_2233_4455_6677);
    check("R5 word64 lit", result_o, 64'h3322_1100_7766_5544);
    run_op("R5 word32", 3'd2, 1'b0, 64'h1234_5678_AABB_CCDD);
    run_op("R6 all64", 3'd3, 1'b1, 64'h0011_2233_4455_6677);
    check("R6 all64 lit", result_o, 64'h7766_5544_3322_1100);
    run_op("R6 all32", 3'd3, 1'b0, 64'hFFFF_FFFF_0011_2233);
    check("R6 all32 lit", result_o, 64'h0000_0000_3322_1100);
  endtask

  task automatic t_counts();
    run_op("R7 lzc64 zero", 3'd4, 1'b1, 64'h0);
    check("R7 lzc64 zero lit", result_o, 64'd64);
    run_op("R7 lzc32 zero", 3'd4, 1'b0, 64'hFFFF_FFFF_0000_0000);
    check("R7 lzc32 zero lit", result_o, 64'd32);
    run_op("R7 lzc64 top", 3'd4, 1'b1, 64'h8000_0000_0000_0000);
    run_op("R7 lzc32 one", 3'd4, 1'b0, 64'h0000_0000_0000_0001);
    check("R7 lzc32 one lit", result_o, 64'd31);
    run_op("R8 lsc64 ones", 3'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 lsc64 ones lit", result_o, 64'd63);
    run_op("R8 lsc64 zero", 3'd5, 1'b1, 64'h0);
    run_op("R8 lsc32 neg", 3'd5, 1'b0, 64'h0000_0000_F000_0000);
    check("R8 lsc32 neg lit", result_o, 64'd3);
    run_op("R8 lsc32 alt", 3'd5, 1'b0, 64'h0000_0000_4000_0000);
    check("R8 lsc32 alt lit", result_o, 64'd0);
  endtask

  task automatic t_narrow();
    for (int op = 0; op < 6; op++) begin
      run_op("R9 upper ignored a", 3'(op), 1'b0, 64'hA5A5_5A5A_8765_4321);
      begin
        logic [63:0] first;
        first = result_o;
        run_op("R9 upper ignored b", 3'(op), 1'b0, 64'h0000_0000_8765_4321);
        check("R9 same result", result_o, first);
        check("R9 high zero", {32'h0, result_o[63:32]}, 64'h0);
      end
    end
  endtask

  task automatic t_reserved();
    run_op("R10 op6", 3'd6, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 op6 lit", result_o, 64'h0);
    run_op("R10 op7", 3'd7, 1'b0, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_stream();
    logic [63:0] exp_prev;
    logic [63:0] x;
    logic [2:0]  op;
    logic        w;
    @(negedge clk);
    x = lfsr; op = 3'd0; w = 1'b1;
    operand_i = x; opsel_i = op; wide_i = w;
    exp_prev = model(op, w, x);
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      check("R2 back-to-back", result_o, exp_prev);
      @(negedge clk);
      lfsr = next_rand(lfsr);
      x = lfsr; op = lfsr[2:0]; w = lfsr[7];
      if (k % 7 == 0) x = x >> lfsr[13:8];
      operand_i = x; opsel_i = op; wide_i = w;
      exp_prev = model(op, w, x);
    end
    @(posedge clk); #1;
    check("R2 last", result_o, exp_prev);
  endtask

  initial begin
    rst = 1'b1; operand_i = '0; opsel_i = '0; wide_i = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_mirror();
    t_swaps();
    t_counts();
    t_narrow();
    t_reserved();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule